// File: doc/BRIEF.md
# SPI Register-Access Slave with Burst

This block lets an external SPI host read and write a 256-entry, 8-bit register file that lives beside it. Each access opens when the host drives chip select low. The host first sends a two-byte header that gives the direction, an 8-bit address and a burst flag. Data bytes follow. The host ties two static pins to set clock polarity and clock phase, so any of the four SPI modes can be used without changing the logic.

The block oversamples chip select, the serial clock and the serial data input with the system clock. It recovers the sample and shift edges from the selected mode and acts on them. On the register-file side it presents an address and a one-cycle write strobe with write data. Read data comes back combinationally from the file for the current address. In burst accesses the address steps by one after each data byte and wraps from 0xFF to 0x00. In single accesses only the first data byte has any effect. Releasing chip select at any point discards a partial byte and returns the header decoder to its start.

Top module: `spi_reg_slave`

## Requirements
- R1: Bits are shifted most significant bit first. The block samples the data input on the leading clock edge when phase is 0 and on the trailing edge when phase is 1. The leading edge is the transition away from the idle level set by the polarity pin. All four polarity/phase combinations give the same register result.
- R2: Header byte 1 carries the direction in bit 7 (1 = read, 0 = write), ignored padding in bits 6..1, and address bit 7 in bit 0. Header byte 2 carries address bits 6..0 in bits 7..1 and the burst flag in bit 0.
- R3: In a write, completing the first data byte raises `regWe` for exactly one clock, with that byte on `regWdata` and the header address on `regAddr`.
- R4: In a read, the first data byte shifted out on `miso` is the register content at the header address, most significant bit first.
- R5: In a burst write, every complete data byte is written, and the address increments by one after each byte, wrapping from 0xFF to 0x00.
- R6: In a burst read, the address increments after the last bit of each byte, and the next byte is shifted out from the new address.
- R7: In a single (non-burst) access, bytes after the first data byte cause no write, leave the address unchanged and read as 0x00.
- R8: `misoOe` is low whenever chip select is high or the access is a write. It is high during the data bytes of a read.
- R9: Raising chip select mid-byte or mid-header discards the partial bits and causes no write. The next access decodes its header from the first bit.
- R10: After reset, `misoOe`, `miso` and `regWe` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rstN | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Static clock polarity select (idle level of sclk) |
| cpha | input | 1 | Static clock phase select (0: sample on leading edge) |
| csN | input | 1 | Active-low chip select |
| sclk | input | 1 | SPI serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| misoOe | output | 1 | Output enable for miso; low means high impedance |
| regAddr | output | 8 | Register-file address |
| regWe | output | 1 | One-cycle register write strobe |
| regWdata | output | 8 | Register write data |
| regRdData | input | 8 | Register read data for regAddr, combinational |

## Verification
The bench builds the block with three synchronizer stages instead of the default two. This lengthens the path from a pin edge to the response and confirms that the serial clock period used still leaves the output bit settled before the host samples it. The bench holds the register file and a separate expected copy of it. It runs single and burst accesses in all four modes, including a burst that wraps across 0xFF. It also runs aborted accesses cut off inside a data byte and inside the header, and compares the whole file against the expected copy after every access.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    PH_HDR1 = 2'd0,
    PH_HDR2 = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  // Strobes from the control unit to the datapath, one clock wide each.
  typedef struct packed {
    logic clear;     // chip select inactive: drop all access state
    logic shiftIn;   // sample edge: shift one bit of mosi in
    logic dirBit;    // first header bit: direction flag
    logic hdr1Done;  // last bit of header byte 1
    logic hdr2Done;  // last bit of header byte 2
    logic byteDone;  // last bit of a data byte
    logic outLoad;   // shift edge opening a data byte: fetch register
    logic outShift;  // shift edge inside a data byte: next bit out
  } strobes_t;
endpackage

// File: rtl/spi_reg_sync.sv
module spi_reg_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES <= 1) begin : gSingle
      logic [WIDTH-1:0] flop;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) flop <= RST_VAL;
        else       flop <= d;
      end
      assign q = flop;
    end else begin : gChain
      logic [STAGES-1:0][WIDTH-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RST_VAL}};
        else       chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cpol,
  input  logic     cpha,
  input  logic     csN,
  input  logic     sclk,
  input  logic     mosi,
  output strobes_t stb,
  output logic     csActive,
  output logic     inData,
  output logic     mosiS
);
  localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(BYTE_W - 1);

  logic [2:0] pinsRaw;
  logic [2:0] pinsSync;
  assign pinsRaw = {csN, sclk, mosi};

  spi_reg_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) uSync (
    .clk (clk),
    .rstN(rstN),
    .d   (pinsRaw),
    .q   (pinsSync)
  );

  logic sclkS;
  logic sclkD;
  assign csActive = ~pinsSync[2];
  assign sclkS    = pinsSync[1];
  assign mosiS    = pinsSync[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkD <= 1'b0;
    else       sclkD <= sclkS;
  end

  logic riseEdge;
  logic fallEdge;
  logic sampleEdge;
  logic shiftEdge;
  assign riseEdge   = sclkS & ~sclkD;
  assign fallEdge   = ~sclkS & sclkD;
  // Sampling on the rising edge happens when polarity and phase agree.
  assign sampleEdge = csActive & ((cpol == cpha) ? riseEdge : fallEdge);
  assign shiftEdge  = csActive & ((cpol == cpha) ? fallEdge : riseEdge);

  phase_e               phase;
  logic [BIT_IDX_W-1:0] bitIdx;
  logic                 lastBit;
  assign lastBit = (bitIdx == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_HDR1;
      bitIdx <= '0;
    end else if (!csActive) begin
      phase  <= PH_HDR1;
      bitIdx <= '0;
    end else if (sampleEdge) begin
      bitIdx <= bitIdx + 1'b1;
      if (lastBit) begin
        unique case (phase)
          PH_HDR1: phase <= PH_HDR2;
          PH_HDR2: phase <= PH_DATA;
          default: phase <= PH_DATA;
        endcase
      end
    end
  end

  assign inData = (phase == PH_DATA);

  always_comb begin
    stb          = '0;
    stb.clear    = ~csActive;
    stb.shiftIn  = sampleEdge;
    stb.dirBit   = sampleEdge & (phase == PH_HDR1) & (bitIdx == '0);
    stb.hdr1Done = sampleEdge & (phase == PH_HDR1) & lastBit;
    stb.hdr2Done = sampleEdge & (phase == PH_HDR2) & lastBit;
    stb.byteDone = sampleEdge & inData & lastBit;
    stb.outLoad  = shiftEdge & inData & (bitIdx == '0);
    stb.outShift = shiftEdge & inData & (bitIdx != '0);
  end
endmodule

// File: rtl/spi_reg_dpath.sv
module spi_reg_dpath
  import spi_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic              mosiS,
  input  logic [BYTE_W-1:0] regRdData,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWe,
  output logic [BYTE_W-1:0] regWdata,
  output logic              miso,
  output logic              misoOe,
  output logic              rwFlag,
  output logic              burst
);
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] byteIn;
  logic [BYTE_W-1:0] outHold;
  logic              rwKnown;
  logic              addrHi;
  logic              firstDone;
  logic              misoBit;
  logic              allow;

  assign byteIn = {shiftReg[BYTE_W-2:0], mosiS};
  // Only the first data byte counts unless the access is a burst.
  assign allow  = burst | ~firstDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      outHold   <= '0;
      rwFlag    <= 1'b0;
      rwKnown   <= 1'b0;
      addrHi    <= 1'b0;
      burst     <= 1'b0;
      firstDone <= 1'b0;
      misoBit   <= 1'b0;
      regAddr   <= '0;
    end else if (stb.clear) begin
      shiftReg  <= '0;
      outHold   <= '0;
      rwFlag    <= 1'b0;
      rwKnown   <= 1'b0;
      addrHi    <= 1'b0;
      burst     <= 1'b0;
      firstDone <= 1'b0;
      misoBit   <= 1'b0;
      regAddr   <= '0;
    end else begin
      if (stb.shiftIn) shiftReg <= byteIn;
      if (stb.dirBit) begin
        rwFlag  <= mosiS;
        rwKnown <= 1'b1;
      end
      if (stb.hdr1Done) addrHi <= mosiS;
      if (stb.hdr2Done) begin
        regAddr   <= {addrHi, byteIn[BYTE_W-1:1]};
        burst     <= mosiS;
        firstDone <= 1'b0;
      end
      if (stb.byteDone) begin
        firstDone <= 1'b1;
        if (burst) regAddr <= regAddr + 1'b1;
      end
      if (stb.outLoad) begin
        misoBit <= allow ? regRdData[BYTE_W-1] : 1'b0;
        outHold <= allow ? {regRdData[BYTE_W-2:0], 1'b0} : '0;
      end else if (stb.outShift) begin
        misoBit <= outHold[BYTE_W-1];
        outHold <= {outHold[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign regWe    = stb.byteDone & rwKnown & ~rwFlag & allow;
  assign regWdata = byteIn;
  assign miso     = misoBit;
  assign misoOe   = ~stb.clear & rwKnown & rwFlag;
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              csN,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  output logic              misoOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWe,
  output logic [BYTE_W-1:0] regWdata,
  input  logic [BYTE_W-1:0] regRdData
);
  strobes_t stb;
  logic     csActive;
  logic     inData;
  logic     mosiS;
  logic     rwFlag;
  logic     burst;

  spi_reg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .cpol    (cpol),
    .cpha    (cpha),
    .csN     (csN),
    .sclk    (sclk),
    .mosi    (mosi),
    .stb     (stb),
    .csActive(csActive),
    .inData  (inData),
    .mosiS   (mosiS)
  );

  spi_reg_dpath uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .mosiS    (mosiS),
    .regRdData(regRdData),
    .regAddr  (regAddr),
    .regWe    (regWe),
    .regWdata (regWdata),
    .miso     (miso),
    .misoOe   (misoOe),
    .rwFlag   (rwFlag),
    .burst    (burst)
  );
endmodule

// File: rtl/spi_reg_slave_checker.sv
module spi_reg_slave_checker (
  input logic       clk,
  input logic       rstN,
  input logic       csActive,
  input logic       inData,
  input logic       rwFlag,
  input logic       burst,
  input logic       misoOe,
  input logic       regWe,
  input logic [7:0] regAddr
);
  AST_WE_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> (csActive && !rwFlag && inData)); // R3

  AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (inData && $past(inData) && (regAddr != $past(regAddr)))
      |-> (regAddr == $past(regAddr) + 8'd1)); // R5

  AST_SINGLE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (inData && $past(inData) && !burst) |-> $stable(regAddr)); // R7

  AST_OE_NOT_WITH_WE: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> !misoOe); // R8
endmodule

bind spi_reg_slave spi_reg_slave_checker uChecker (
  .clk     (clk),
  .rstN    (rstN),
  .csActive(csActive),
  .inData  (inData),
  .rwFlag  (rwFlag),
  .burst   (burst),
  .misoOe  (misoOe),
  .regWe   (regWe),
  .regAddr (regAddr)
);

// File: tb/spi_reg_slave_test.sv
`timescale 1ns/1ps
module spi_reg_slave_test;
  localparam int HALF = 8;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpolPin = 1'b0;
  logic       cphaPin = 1'b0;
  logic       csN = 1'b1;
  logic       sclk = 1'b0;
  logic       mosi = 1'b0;
  logic       miso;
  logic       misoOe;
  logic [7:0] regAddr;
  logic       regWe;
  logic [7:0] regWdata;
  logic [7:0] regRdData;

  always #2 clk = ~clk;

  spi_reg_slave #(.SYNC_STAGES(3)) uut (
    .clk(clk), .rstN(rstN), .cpol(cpolPin), .cpha(cphaPin), .csN(csN),
    .sclk(sclk), .mosi(mosi), .miso(miso), .misoOe(misoOe),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata), .regRdData(regRdData)
  );

  function automatic logic [7:0] initVal(int i);
    return 8'(i * 37 + 11);
  endfunction

  // Register file beside the block, and the bench's expected copy.
  logic [7:0] mem [256];
  logic [7:0] refMem [256];
  assign regRdData = mem[regAddr];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= initVal(i);
    end else if (regWe) begin
      mem[regAddr] <= regWdata;
    end
  end

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int idleCnt = 0;
  int idleBad = 0;
  logic [7:0] txBuf [16];
  logic [7:0] rxBuf [16];
  int oeHighData;
  int oeLowData;
  int oeHighAny;

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, actual, expected);
    end
  endtask

  // Per-clock comparison against the idle expectation: once chip select has
  // been high for a few cycles the block must drive nothing.
  always @(negedge clk) begin
    cycles++;
    if (rstN && csN) idleCnt++;
    else idleCnt = 0;
    if (idleCnt > 6 && (misoOe || regWe)) idleBad++;
    if (cycles > WATCHDOG) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setHdr(input bit rd, input logic [7:0] addr, input bit bst);
    txBuf[0] = {rd, 6'b000000, addr[7]};
    txBuf[1] = {addr[6:0], bst};
  endtask

  task automatic sampleMiso(input int i);
    if (misoOe) oeHighAny++;
    if (i >= 16) begin
      rxBuf[i / 8][7 - (i % 8)] = miso;
      if (misoOe) oeHighData++;
      else oeLowData++;
    end
  endtask

  task automatic xfer(input bit pol, input bit pha, input int nBits);
    @(negedge clk);
    cpolPin = pol; cphaPin = pha; sclk = pol; mosi = 1'b0;
    waitCyc(HALF);
    csN = 1'b0;
    waitCyc(HALF);
    oeHighData = 0; oeLowData = 0; oeHighAny = 0;
    for (int i = 0; i < nBits; i++) begin
      logic bv;
      bv = txBuf[i / 8][7 - (i % 8)];
      if (!pha) begin
        mosi = bv;
        waitCyc(HALF);
        sampleMiso(i);
        sclk = ~sclk;
        waitCyc(HALF);
        sclk = ~sclk;
      end else begin
        sclk = ~sclk;
        mosi = bv;
        waitCyc(HALF);
        sampleMiso(i);
        sclk = ~sclk;
        waitCyc(HALF);
      end
    end
    waitCyc(HALF);
    csN = 1'b1;
    waitCyc(2 * HALF);
  endtask

  function automatic int memMismatch();
    int n = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== refMem[i]) n++;
    return n;
  endfunction

  task automatic writeOne(input bit pol, input bit pha, input logic [7:0] a, input logic [7:0] d);
    setHdr(1'b0, a, 1'b0);
    txBuf[2] = d;
    xfer(pol, pha, 24);
    refMem[a] = d;
  endtask

  task automatic readOne(input bit pol, input bit pha, input logic [7:0] a);
    setHdr(1'b1, a, 1'b0);
    txBuf[2] = 8'h00;
    xfer(pol, pha, 24);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) refMem[i] = initVal(i);
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(3);
    check("R10 oe after reset", misoOe, 0);
    check("R10 miso after reset", miso, 0);
    check("R10 we after reset", regWe, 0);

    // Single write and read in mode 0.
    writeOne(1'b0, 1'b0, 8'h12, 8'hA5);
    check("R3 single write file", memMismatch(), 0);
    check("R8 oe during write", oeHighAny, 0);
    readOne(1'b0, 1'b0, 8'h12);
    check("R4 single read", rxBuf[2], 8'hA5);
    check("R8 oe during read data", oeLowData, 0);

    // The remaining three modes, each with its own address and data.
    for (int m = 1; m < 4; m++) begin
      logic [7:0] a;
      logic [7:0] d;
      a = 8'(8'h40 + m);
      d = 8'(8'h3C ^ (m * 8'h51));
      writeOne(m[1], m[0], a, d);
      check("R1 write in mode", memMismatch(), 0);
      readOne(m[1], m[0], a);
      check("R1 read in mode", rxBuf[2], d);
    end

    // Address bit 7 placement in header byte 1.
    writeOne(1'b0, 1'b1, 8'h80, 8'h5A);
    check("R2 high address write", memMismatch(), 0);
    readOne(1'b1, 1'b0, 8'h00);
    check("R2 low address untouched", rxBuf[2], refMem[0]);
    readOne(1'b1, 1'b1, 8'h80);
    check("R2 high address read", rxBuf[2], 8'h5A);

    // Burst write across the top of the address space.
    setHdr(1'b0, 8'hFE, 1'b1);
    for (int k = 0; k < 4; k++) begin
      txBuf[2 + k] = 8'(8'hC0 + k * 3);
      refMem[8'(8'hFE + k)] = txBuf[2 + k];
    end
    xfer(1'b1, 1'b1, 48);
    check("R5 burst write wrap", memMismatch(), 0);

    // Burst read starting one below, five bytes.
    setHdr(1'b1, 8'hFD, 1'b1);
    for (int k = 0; k < 5; k++) txBuf[2 + k] = 8'h00;
    xfer(1'b0, 1'b1, 56);
    for (int k = 0; k < 5; k++) check("R6 burst read byte", rxBuf[2 + k], refMem[8'(8'hFD + k)]);
    check("R8 oe burst read", oeLowData, 0);

    // Single write with trailing bytes: only the first counts.
    setHdr(1'b0, 8'h20, 1'b0);
    txBuf[2] = 8'h77; txBuf[3] = 8'h88; txBuf[4] = 8'h99;
    refMem[8'h20] = 8'h77;
    xfer(1'b0, 1'b0, 40);
    check("R7 single write extra bytes", memMismatch(), 0);

    // Single read with trailing bytes: they read as zero.
    setHdr(1'b1, 8'h12, 1'b0);
    txBuf[2] = 8'h00; txBuf[3] = 8'h00; txBuf[4] = 8'h00;
    xfer(1'b1, 1'b0, 40);
    check("R7 single read first", rxBuf[2], refMem[8'h12]);
    check("R7 single read extra 1", rxBuf[3], 0);
    check("R7 single read extra 2", rxBuf[4], 0);

    // Abort inside a data byte: no write.
    setHdr(1'b0, 8'h30, 1'b0);
    txBuf[2] = 8'hFF;
    xfer(1'b0, 1'b0, 21);
    check("R9 abort mid data", memMismatch(), 0);
    // Abort inside the header, then a clean read must decode afresh.
    setHdr(1'b1, 8'hFF, 1'b1);
    xfer(1'b0, 1'b0, 11);
    readOne(1'b0, 1'b0, 8'h30);
    check("R9 fresh read after abort", rxBuf[2], refMem[8'h30]);
    writeOne(1'b1, 1'b1, 8'h30, 8'h1E);
    check("R9 fresh write after abort", memMismatch(), 0);

    check("R8 idle oe and we low", idleBad, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule